// File: doc/BRIEF.md
# Amplifier Protection and Fault Controller

This block is the control state machine that sits over a bridge-tied class-D power stage. It takes a run request, the short-circuit and DC-offset detector flags, a die temperature reading, a supply-in-range flag and a millisecond tick. From these it decides whether the output bridge may switch, and it drives an active-low open-drain fault line. The fault line is modelled as a pull-low request: 1 pulls the line low, and 0 releases it.

Each protection source has its own clearing rule. A short circuit is latched and reported, and it clears when the run request goes low. A DC-offset fault is latched and reported until power-on reset. Over-temperature disables the bridge and clears itself through hysteresis, and it is never reported. A supply out of range disables the bridge without latching and without reporting. Whenever the bridge is allowed again, it comes up only after a timed start-up of a set number of millisecond ticks. When the automatic recovery input is set, the fault line is fed back into the run request inside the block through a register. This clears a short-circuit latch without any external loop.

Top module: `amp_guard_ctrl`

## Requirements
- R1: After reset, `bridge_en_o` is 0 and `fault_pull_o` is 0.
- R2: With `run_i` low at a clock edge, `bridge_en_o` is 0 after that edge.
- R3: Once nothing blocks operation, the first edge enters start-up and ignores the tick. `bridge_en_o` goes to 1 on the edge that samples the STARTUP_MS-th (default 14) `ms_tick_i` pulse after that.
- R4: `short_det_i` sampled high while the run request is in effect sets a latch. After that edge `fault_pull_o` is 1 and `bridge_en_o` is 0, and both stay that way after `short_det_i` falls.
- R5: The short-circuit latch clears on an edge where the effective run request is low. `fault_pull_o` is 0 after that edge unless a DC fault is latched.
- R6: With `auto_recover_i` high, a short fault pulls the fault line for exactly one cycle, releases it, and then the bridge restarts through the start-up of R3.
- R7: `dc_det_i` sampled high latches a DC fault: `fault_pull_o` becomes 1 and `bridge_en_o` becomes 0. Taking `run_i` low does not clear it; only reset does.
- R8: A die temperature above TRIP_C (default 150, unsigned degrees in `die_temp_i`) sets the thermal flag on the next edge, and the bridge is off one edge later. The value TRIP_C itself does not trip. `fault_pull_o` is not affected.
- R9: The thermal flag clears when the temperature is at or below TRIP_C-HYST_C (default 135), and it holds at values between. After it clears, the bridge restarts through R3.
- R10: `supply_ok_i` low turns the bridge off after that edge without latching or reporting. When the supply recovers, the bridge restarts through R3.
- R11: `fault_pull_o` rises only after `short_det_i` or `dc_det_i` was sampled high, and `bridge_en_o` is never 1 while `fault_pull_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset, the supply power-on reset |
| run_i | input | 1 | Run request; low requests shutdown |
| auto_recover_i | input | 1 | Feed the fault line back into the run request |
| short_det_i | input | 1 | Short-circuit detector flag |
| dc_det_i | input | 1 | DC-offset detector flag |
| die_temp_i | input | TEMP_W | Die temperature, unsigned degrees |
| supply_ok_i | input | 1 | Supply within its valid range |
| ms_tick_i | input | 1 | One-cycle pulse per millisecond |
| bridge_en_o | output | 1 | Output bridge enable |
| fault_pull_o | output | 1 | 1 pulls the open-drain fault line low |

## Verification
Shutdown, supply loss, short and DC faults act on the edge that samples them. Temperature acts one edge later, because it passes through the hysteresis flag first. The bridge enable rises on the edge that samples the last start-up tick. Automatic recovery releases the fault line two edges after the short and re-enters start-up on the third. The bench drives inputs on the falling edge and samples just before the next falling edge, so each directed check waits exactly that number of edges. The random phase compares every cycle against a bench model that advances at the same rising edge.

// File: rtl/amp_guard_pkg.sv
package amp_guard_pkg;
  typedef enum logic [1:0] {
    SEQ_OFF  = 2'd0,
    SEQ_RAMP = 2'd1,
    SEQ_ON   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/amp_guard_latch.sv
module amp_guard_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // clear wins over set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (clr_i) q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
  end
endmodule

// File: rtl/amp_guard_thermal.sv
module amp_guard_thermal #(
  parameter int TEMP_W = 8,
  parameter int TRIP_C = 150,
  parameter int HYST_C = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TEMP_W-1:0] temp_i,
  output logic              hot_o
);
  localparam logic [TEMP_W-1:0] TripV = TEMP_W'(TRIP_C);
  localparam logic [TEMP_W-1:0] RelV  = TEMP_W'(TRIP_C - HYST_C);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              hot_o <= 1'b0;
    else if (temp_i > TripV)  hot_o <= 1'b1;
    else if (temp_i <= RelV)  hot_o <= 1'b0;
  end
endmodule

// File: rtl/amp_guard_seq.sv
module amp_guard_seq
  import amp_guard_pkg::*;
#(
  parameter int STARTUP_MS = 14
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic block_i,
  input  logic tick_i,
  output logic en_o
);
  localparam int CntW = $clog2(STARTUP_MS + 1);
  localparam logic [CntW-1:0] LastCnt = CntW'(STARTUP_MS - 1);

  seq_state_e      state_q, state_d;
  logic [CntW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (block_i) begin
      state_d = SEQ_OFF;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        SEQ_OFF: begin
          state_d = SEQ_RAMP;
          cnt_d   = '0;
        end
        SEQ_RAMP: if (tick_i) begin
          if (cnt_q == LastCnt) state_d = SEQ_ON;
          else                  cnt_d   = cnt_q + 1'b1;
        end
        SEQ_ON: ;
        default: state_d = SEQ_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_OFF;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign en_o = (state_q == SEQ_ON);
endmodule

// File: rtl/amp_guard_ctrl.sv
module amp_guard_ctrl #(
  parameter int TEMP_W     = 8,
  parameter int TRIP_C     = 150,
  parameter int HYST_C     = 15,
  parameter int STARTUP_MS = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              auto_recover_i,
  input  logic              short_det_i,
  input  logic              dc_det_i,
  input  logic [TEMP_W-1:0] die_temp_i,
  input  logic              supply_ok_i,
  input  logic              ms_tick_i,
  output logic              bridge_en_o,
  output logic              fault_pull_o
);
  logic sc_q, dc_q, hot_q, run_eff, block;

  // fault_pull_o comes from flops only, so the loopback is registered
  assign run_eff = run_i & ~(auto_recover_i & fault_pull_o);

  amp_guard_latch u_sc (
    .clk_i, .rst_ni,
    .set_i (short_det_i),
    .clr_i (~run_eff),
    .q_o   (sc_q)
  );

  // only power-on reset clears the DC latch
  amp_guard_latch u_dc (
    .clk_i, .rst_ni,
    .set_i (dc_det_i),
    .clr_i (1'b0),
    .q_o   (dc_q)
  );

  amp_guard_thermal #(
    .TEMP_W (TEMP_W),
    .TRIP_C (TRIP_C),
    .HYST_C (HYST_C)
  ) u_therm (
    .clk_i, .rst_ni,
    .temp_i (die_temp_i),
    .hot_o  (hot_q)
  );

  assign block = ~run_eff | sc_q | short_det_i | dc_q | dc_det_i |
                 hot_q | ~supply_ok_i;

  amp_guard_seq #(.STARTUP_MS(STARTUP_MS)) u_seq (
    .clk_i, .rst_ni,
    .block_i (block),
    .tick_i  (ms_tick_i),
    .en_o    (bridge_en_o)
  );

  assign fault_pull_o = sc_q | dc_q;
endmodule

// File: rtl/amp_guard_chk.sv
module amp_guard_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic run_i,
  input logic auto_recover_i,
  input logic short_det_i,
  input logic dc_det_i,
  input logic supply_ok_i,
  input logic ms_tick_i,
  input logic bridge_en_o,
  input logic fault_pull_o
);
  p_stop_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !bridge_en_o);

  p_start_on_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bridge_en_o) |-> $past(ms_tick_i));

  p_short_latch_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (short_det_i && run_i && !auto_recover_i) |=> (fault_pull_o && !bridge_en_o));

  p_dc_latch_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dc_det_i |=> (fault_pull_o && !bridge_en_o));

  p_supply_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> !bridge_en_o);

  p_fault_source_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_pull_o) |-> $past(short_det_i || dc_det_i));

  p_no_en_in_fault_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_pull_o |-> !bridge_en_o);
endmodule

bind amp_guard_ctrl amp_guard_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .run_i          (run_i),
  .auto_recover_i (auto_recover_i),
  .short_det_i    (short_det_i),
  .dc_det_i       (dc_det_i),
  .supply_ok_i    (supply_ok_i),
  .ms_tick_i      (ms_tick_i),
  .bridge_en_o    (bridge_en_o),
  .fault_pull_o   (fault_pull_o)
);

// File: tb/sim_amp_guard_ctrl.sv
`timescale 1ns/1ps
module sim_amp_guard_ctrl;
  localparam int TW = 8;
  localparam int NMS = 14;

  logic clk = 1'b0, rst_n = 1'b0;
  logic run = 1'b0, auto = 1'b0, shrt = 1'b0, dcd = 1'b0, sup = 1'b1, tick = 1'b0;
  logic [TW-1:0] temp = 8'd25;
  logic en, flt;
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0, cmp_on = 1'b0;

  always #5 clk = ~clk;

  amp_guard_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .auto_recover_i(auto),
    .short_det_i(shrt), .dc_det_i(dcd), .die_temp_i(temp),
    .supply_ok_i(sup), .ms_tick_i(tick), .bridge_en_o(en), .fault_pull_o(flt)
  );

  // bench model built from the requirements
  bit m_sc, m_dc, m_hot, m_en;
  int m_st, m_cnt;
  function automatic bit hot_next(bit h, int t);
    if (t > 150) return 1'b1;
    if (t <= 135) return 1'b0;
    return h;
  endfunction
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sc = 0; m_dc = 0; m_hot = 0; m_st = 0; m_cnt = 0;
    end else begin
      bit reff, blk;
      reff = run && !(auto && (m_sc || m_dc));
      blk  = !reff || m_sc || shrt || m_dc || dcd || m_hot || !sup;
      if (blk) begin m_st = 0; m_cnt = 0; end
      else if (m_st == 0) begin m_st = 1; m_cnt = 0; end
      else if (m_st == 1 && tick) begin
        if (m_cnt == NMS - 1) m_st = 2; else m_cnt++;
      end
      m_sc  = !reff ? 1'b0 : (shrt ? 1'b1 : m_sc);
      m_dc  = m_dc || dcd;
      m_hot = hot_next(m_hot, int'(temp));
    end
    m_en = (m_st == 2);
  end

  task automatic chk(string tag, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; cyc(1); tick = 1'b0; cyc(1);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  // random phase: compare each cycle with the model
  always @(negedge clk) if (cmp_on) begin
    chk("R11 model en", en, m_en);
    chk("R11 model flt", flt, m_sc || m_dc);
  end

  initial begin
    void'($urandom(32'd1234));
    cyc(2);
    chk("R1 en", en, 1'b0);
    chk("R1 flt", flt, 1'b0);
    rst_n = 1'b1; cyc(1);
    chk("R1 en after release", en, 1'b0);

    // R3 start-up
    run = 1'b1; cyc(1);
    ticks(NMS - 1);
    chk("R3 en before last tick", en, 1'b0);
    ticks(1);
    chk("R3 en after last tick", en, 1'b1);

    // R2 shutdown
    run = 1'b0; cyc(1);
    chk("R2 en", en, 1'b0);
    chk("R2 flt", flt, 1'b0);
    run = 1'b1; cyc(1); ticks(NMS);
    chk("R3 restart", en, 1'b1);

    // R4 short latch
    shrt = 1'b1; cyc(1); shrt = 1'b0;
    chk("R4 flt", flt, 1'b1);
    chk("R4 en", en, 1'b0);
    cyc(5); ticks(2);
    chk("R4 held flt", flt, 1'b1);
    chk("R4 held en", en, 1'b0);
    // R5 clear by run low
    run = 1'b0; cyc(1);
    chk("R5 flt", flt, 1'b0);
    run = 1'b1; cyc(1); ticks(NMS);
    chk("R5 en back", en, 1'b1);

    // R6 auto recovery
    auto = 1'b1;
    shrt = 1'b1; cyc(1); shrt = 1'b0;
    chk("R6 flt pulled", flt, 1'b1);
    cyc(1);
    chk("R6 flt released", flt, 1'b0);
    chk("R6 en off", en, 1'b0);
    cyc(1); ticks(NMS - 1);
    chk("R6 en early", en, 1'b0);
    ticks(1);
    chk("R6 en restarted", en, 1'b1);
    auto = 1'b0;

    // R8 thermal boundary and trip
    temp = 8'd150; cyc(3);
    chk("R8 at trip no effect", en, 1'b1);
    temp = 8'd151; cyc(1);
    chk("R8 one edge still on", en, 1'b1);
    cyc(1);
    chk("R8 en off", en, 1'b0);
    chk("R8 flt silent", flt, 1'b0);
    // R9 hysteresis
    temp = 8'd136; cyc(3); ticks(NMS);
    chk("R9 held at 136", en, 1'b0);
    temp = 8'd135; cyc(2); ticks(NMS);
    chk("R9 released at 135", en, 1'b1);
    temp = 8'd25;

    // R10 supply
    sup = 1'b0; cyc(1);
    chk("R10 en", en, 1'b0);
    chk("R10 flt", flt, 1'b0);
    sup = 1'b1; cyc(1); ticks(NMS);
    chk("R10 restart", en, 1'b1);

    // R7 DC latch
    dcd = 1'b1; cyc(1); dcd = 1'b0;
    chk("R7 flt", flt, 1'b1);
    chk("R7 en", en, 1'b0);
    run = 1'b0; cyc(2); run = 1'b1; cyc(1); ticks(NMS);
    chk("R7 flt after run low", flt, 1'b1);
    chk("R7 en stays off", en, 1'b0);
    rst_n = 1'b0; cyc(1);
    chk("R7 cleared by reset", flt, 1'b0);
    rst_n = 1'b1; cyc(1);

    // random phase against the model
    cmp_on = 1'b1;
    for (int i = 0; i < 20000; i++) begin
      tick = ($urandom % 3) == 0;
      shrt = ($urandom % 400) == 0;
      run  = ($urandom % 300) != 0;
      sup  = ($urandom % 300) != 0;
      if (($urandom % 200) == 0) auto = $urandom % 2;
      if (($urandom % 150) == 0) temp = TW'(120 + $urandom % 50);
      cyc(1);
    end
    cmp_on = 1'b0;
    finish_run();
  end
endmodule